// File: doc/BRIEF.md
# Result Destination Steering

This block decides where the result of one decoded instruction is written. It also forms the scratchpad address for that write. It sees the instruction group, an 8-bit destination location byte, a 3-bit destination register selector, a 32-bit address mask and the current contents of the integer register file. From these it produces two independent write requests: one for a register file and one for the scratchpad. The arithmetic that makes the result is handled elsewhere.

Integer and control results take exactly one path, chosen by a single location bit. Floating-point results always update a floating-point register. The same bit can also copy one 64-bit half of that 128-bit register to the scratchpad. The scratchpad address always comes from an integer register, even for floating-point instructions. It is cut to either the full scratchpad or its small low window.

The block is purely combinational, so its outputs follow its inputs within the same cycle.

Top module: `wbd_dest_steer`

## Requirements
- R1: When `valid_i` is 0, every output is 0.
- R2: The scratchpad address is the low 32 bits of integer register `sel_i`, XORed with `mask_i`. When `loc_i[1:0]` is 0, it is cut to its low 15 bits.
- R3: When `loc_i[1:0]` is nonzero, only the low 11 bits of that XOR are kept, and `sp_addr_o[14:11]` is 0.
- R4: For group code 0 (integer) or 2 (control), `loc_i[2]`=0 gives a scratchpad write only. `loc_i[2]`=1 gives a register write only, with `reg_file_o`=0 (integer file).
- R5: For group code 1 (floating point), the register write is always requested with `reg_file_o`=1 (floating-point file). The scratchpad write is requested exactly when `loc_i[2]`=1.
- R6: `sp_half_o` equals `loc_i[7]` on a floating-point scratchpad write (0 = bits 63:0, 1 = bits 127:64). It is 0 in every other case.
- R7: `reg_idx_o` equals `sel_i` whenever `reg_we_o` is 1, and is 0 otherwise. `sp_addr_o` is 0 whenever `sp_we_o` is 0.
- R8: Bits 6:3 of `loc_i` have no effect on any output.
- R9: Group code 3 requests no write of either kind.
- R10: Floating-point scratchpad addresses are taken from the integer registers. Bits 63:32 of the chosen register never affect the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Instruction present |
| group_i | input | 2 | 0 integer, 1 floating point, 2 control, 3 none |
| loc_i | input | 8 | Destination location byte |
| sel_i | input | 3 | Destination / address register selector |
| mask_i | input | 32 | Write address mask |
| int_regs_i | input | 512 | Integer registers, register k at bits 64k+63:64k |
| reg_we_o | output | 1 | Register write request |
| reg_idx_o | output | 3 | Register index |
| reg_file_o | output | 1 | 0 integer file, 1 floating-point file |
| sp_we_o | output | 1 | Scratchpad write request |
| sp_addr_o | output | 15 | Scratchpad write address |
| sp_half_o | output | 1 | Half of the floating-point register to store |

## Verification
Each group is driven with both settings of the destination bit. This separates the exclusive integer/control routing from the additive floating-point routing. Each width code (0 and 1–3) is driven with masks and register values that set address bits above bit 10. Any truncation mistake then shows up as nonzero upper address bits. The bench also repeats stimuli with only the reserved bits flipped, and uses registers whose upper 32 bits are nonzero, to show that neither reaches the outputs. Random instructions across all four group codes, with `valid_i` toggling, are compared against a behavioural model each cycle.

// File: rtl/wbd_pkg.sv
package wbd_pkg;

    typedef enum logic [1:0] {
        GRP_INT  = 2'd0,
        GRP_FP   = 2'd1,
        GRP_CTL  = 2'd2,
        GRP_NONE = 2'd3
    } grp_e;

    // Decoded fields of the destination location byte
    typedef struct packed {
        logic narrow;    // address cut to the small window
        logic alt_dest;  // selects the alternate / extra destination
        logic hi_half;   // upper 64-bit half for floating-point stores
    } cloc_t;

    typedef struct packed {
        logic reg_we;
        logic reg_fp;
        logic sp_we;
        logic sp_hi;
    } route_t;

    function automatic route_t steer(input grp_e g, input cloc_t c);
        route_t r;
        r = '0;
        case (g)
            GRP_INT, GRP_CTL: begin
                r.reg_we = c.alt_dest;
                r.sp_we  = ~c.alt_dest;
            end
            GRP_FP: begin
                r.reg_we = 1'b1;
                r.reg_fp = 1'b1;
                r.sp_we  = c.alt_dest;
                r.sp_hi  = c.alt_dest & c.hi_half;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wbd_loc_decode.sv
module wbd_loc_decode
    import wbd_pkg::*;
(
    input  logic [7:0] loc_i,
    output cloc_t      cloc_o
);
    // Bits 6:3 are reserved; they are folded away here on purpose
    logic unused_rsvd;
    assign unused_rsvd = ^loc_i[6:3];

    always_comb begin
        cloc_o.narrow   = |loc_i[1:0];
        cloc_o.alt_dest = loc_i[2];
        cloc_o.hi_half  = loc_i[7];
    end
endmodule

// File: rtl/wbd_addr_gen.sv
module wbd_addr_gen #(
    parameter int XLEN      = 64,
    parameter int NREG      = 8,
    parameter int MASK_W    = 32,
    parameter int AW_WIDE   = 15,
    parameter int AW_NARROW = 11
) (
    input  logic [NREG*XLEN-1:0]     regs_i,
    input  logic [$clog2(NREG)-1:0]  sel_i,
    input  logic [MASK_W-1:0]        mask_i,
    input  logic                     narrow_i,
    output logic [AW_WIDE-1:0]       addr_o
);
    localparam logic [AW_WIDE-1:0] NARROW_KEEP =
        AW_WIDE'((64'd1 << AW_NARROW) - 64'd1);

    logic [MASK_W-1:0] low_words [NREG];
    logic [NREG-1:0]   unused_hi;
    logic [MASK_W-1:0] mixed;
    logic              unused_top;

    for (genvar i = 0; i < NREG; i++) begin : g_unpack
        assign low_words[i] = regs_i[i*XLEN +: MASK_W];
        assign unused_hi[i] = ^regs_i[i*XLEN+MASK_W +: XLEN-MASK_W];
    end

    assign mixed      = low_words[sel_i] ^ mask_i;
    assign unused_top = ^mixed[MASK_W-1:AW_WIDE];
    assign addr_o     = mixed[AW_WIDE-1:0] & (narrow_i ? NARROW_KEEP : '1);
endmodule

// File: rtl/wbd_route.sv
module wbd_route
    import wbd_pkg::*;
(
    input  logic   valid_i,
    input  grp_e   grp_i,
    input  cloc_t  cloc_i,
    output route_t route_o
);
    always_comb begin
        route_o = valid_i ? steer(grp_i, cloc_i) : '0;
    end
endmodule

// File: rtl/wbd_dest_steer.sv
module wbd_dest_steer
    import wbd_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int NREG      = 8,
    parameter int MASK_W    = 32,
    parameter int AW_WIDE   = 15,
    parameter int AW_NARROW = 11,
    localparam int SEL_W    = $clog2(NREG)
) (
    input  logic                 valid_i,
    input  logic [1:0]           group_i,
    input  logic [7:0]           loc_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic [MASK_W-1:0]    mask_i,
    input  logic [NREG*XLEN-1:0] int_regs_i,
    output logic                 reg_we_o,
    output logic [SEL_W-1:0]     reg_idx_o,
    output logic                 reg_file_o,
    output logic                 sp_we_o,
    output logic [AW_WIDE-1:0]   sp_addr_o,
    output logic                 sp_half_o
);
    cloc_t              cloc;
    route_t             rt;
    logic [AW_WIDE-1:0] addr;

    wbd_loc_decode u_dec (
        .loc_i  (loc_i),
        .cloc_o (cloc)
    );

    wbd_addr_gen #(
        .XLEN(XLEN), .NREG(NREG), .MASK_W(MASK_W),
        .AW_WIDE(AW_WIDE), .AW_NARROW(AW_NARROW)
    ) u_addr (
        .regs_i   (int_regs_i),
        .sel_i    (sel_i),
        .mask_i   (mask_i),
        .narrow_i (cloc.narrow),
        .addr_o   (addr)
    );

    wbd_route u_route (
        .valid_i (valid_i),
        .grp_i   (grp_e'(group_i)),
        .cloc_i  (cloc),
        .route_o (rt)
    );

    assign reg_we_o   = rt.reg_we;
    assign reg_file_o = rt.reg_fp;
    assign reg_idx_o  = rt.reg_we ? sel_i : '0;
    assign sp_we_o    = rt.sp_we;
    assign sp_addr_o  = rt.sp_we ? addr : '0;
    assign sp_half_o  = rt.sp_hi;
endmodule

// File: rtl/wbd_dest_steer_chk.sv
module wbd_dest_steer_chk #(
    parameter int AW_WIDE   = 15,
    parameter int AW_NARROW = 11
) (
    input logic               valid_i,
    input logic [1:0]         group_i,
    input logic [7:0]         loc_i,
    input logic               reg_we_o,
    input logic               reg_file_o,
    input logic               sp_we_o,
    input logic [AW_WIDE-1:0] sp_addr_o,
    input logic               sp_half_o
);
    always_comb begin
        if (!valid_i)
            a_r1_idle: assert (!reg_we_o && !sp_we_o && !sp_half_o);
        if (valid_i && group_i == 2'd3)
            a_r9_no_write: assert (!reg_we_o && !sp_we_o);
        if (valid_i && group_i == 2'd1)
            a_r5_fp_reg: assert (reg_we_o && reg_file_o && (sp_we_o == loc_i[2]));
        if (valid_i && (group_i == 2'd0 || group_i == 2'd2))
            a_r4_exclusive: assert ((reg_we_o != sp_we_o) && !reg_file_o);
        if (sp_we_o && loc_i[1:0] != 2'b00)
            a_r3_narrow: assert (sp_addr_o[AW_WIDE-1:AW_NARROW] == '0);
        if (sp_half_o)
            a_r6_half: assert (sp_we_o && group_i == 2'd1 && loc_i[7]);
    end
endmodule

bind wbd_dest_steer wbd_dest_steer_chk #(
    .AW_WIDE(AW_WIDE), .AW_NARROW(AW_NARROW)
) u_chk (
    .valid_i    (valid_i),
    .group_i    (group_i),
    .loc_i      (loc_i),
    .reg_we_o   (reg_we_o),
    .reg_file_o (reg_file_o),
    .sp_we_o    (sp_we_o),
    .sp_addr_o  (sp_addr_o),
    .sp_half_o  (sp_half_o)
);

// File: tb/sim_wbd_dest_steer.sv
module sim_wbd_dest_steer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid;
    logic [1:0]  grp;
    logic [7:0]  loc;
    logic [2:0]  sel;
    logic [31:0] mask;
    logic [511:0] regs;
    logic        reg_we, reg_file, sp_we, sp_half;
    logic [2:0]  reg_idx;
    logic [14:0] sp_addr;

    logic [63:0] rf [8];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    always_comb for (int k = 0; k < 8; k++) regs[k*64 +: 64] = rf[k];

    wbd_dest_steer u0 (
        .valid_i(valid), .group_i(grp), .loc_i(loc), .sel_i(sel),
        .mask_i(mask), .int_regs_i(regs),
        .reg_we_o(reg_we), .reg_idx_o(reg_idx), .reg_file_o(reg_file),
        .sp_we_o(sp_we), .sp_addr_o(sp_addr), .sp_half_o(sp_half)
    );

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference, written from the requirements
    task automatic compare(input string tag);
        bit e_reg, e_sp, e_hi, e_fp;
        longint e_addr;
        int window;
        e_reg = 0; e_sp = 0; e_hi = 0; e_fp = 0; e_addr = 0;
        if (valid) begin
            if (grp == 2'd0 || grp == 2'd2) begin
                e_reg = loc[2];
                e_sp  = !loc[2];
            end else if (grp == 2'd1) begin
                e_reg = 1; e_fp = 1;
                e_sp  = loc[2];
                e_hi  = loc[2] && loc[7];
            end
        end
        window = (loc[1:0] == 0) ? 32768 : 2048;
        if (e_sp) e_addr = longint'((rf[sel] & 64'hFFFF_FFFF) ^ {32'd0, mask}) % window;
        chk(tag, "reg_we",   reg_we,   e_reg);
        chk(tag, "reg_file", reg_file, e_fp);
        chk(tag, "reg_idx",  reg_idx,  e_reg ? sel : 0);
        chk(tag, "sp_we",    sp_we,    e_sp);
        chk(tag, "sp_addr",  sp_addr,  e_addr);
        chk(tag, "sp_half",  sp_half,  e_hi);
    endtask

    task automatic apply(input string tag, input bit v, input logic [1:0] g,
                         input logic [7:0] l, input logic [2:0] s, input logic [31:0] m);
        @(posedge clk);
        valid = v; grp = g; loc = l; sel = s; mask = m;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        valid = 0; grp = 0; loc = 0; sel = 0; mask = 0;
        for (int k = 0; k < 8; k++)
            rf[k] = {32'hDEAD_0000 | k, 32'h1357_9BDF * (k + 1)};
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1 reset");
        // R1: busy-looking inputs with valid low
        apply("R1", 0, 2'd1, 8'hFF, 3'd5, 32'hFFFF_FFFF);
        // R2: wide window on integer scratchpad write
        apply("R2", 1, 2'd0, 8'h00, 3'd3, 32'h0000_7A5C);
        apply("R2", 1, 2'd2, 8'h00, 3'd7, 32'hFFFF_FFFF);
        // R3: each narrow width code
        apply("R3", 1, 2'd0, 8'h01, 3'd3, 32'h0000_7A5C);
        apply("R3", 1, 2'd2, 8'h02, 3'd6, 32'h1234_FFFF);
        apply("R3", 1, 2'd1, 8'h07, 3'd1, 32'hFFFF_F800);
        // R4: integer and control, both destination settings
        apply("R4", 1, 2'd0, 8'h04, 3'd2, 32'h0);
        apply("R4", 1, 2'd2, 8'h04, 3'd6, 32'h0);
        apply("R4", 1, 2'd2, 8'h80, 3'd4, 32'h55);
        // R5 R6: floating point register-only and both halves
        apply("R5", 1, 2'd1, 8'h80, 3'd5, 32'h0);
        apply("R6", 1, 2'd1, 8'h04, 3'd5, 32'h0F0F);
        apply("R6", 1, 2'd1, 8'h84, 3'd0, 32'h0F0F);
        // R7: index and address gating
        apply("R7", 1, 2'd0, 8'h04, 3'd7, 32'hFFFF);
        // R9: group code 3
        apply("R9", 1, 2'd3, 8'h04, 3'd4, 32'hFFFF);
        apply("R9", 1, 2'd3, 8'h84, 3'd4, 32'hFFFF);
        // R10: upper register half ignored
        rf[2] = 64'hFFFF_FFFF_0000_0123;
        apply("R10", 1, 2'd1, 8'h84, 3'd2, 32'h0);
        rf[2] = 64'h0000_0000_0000_0123;
        apply("R10", 1, 2'd1, 8'h84, 3'd2, 32'h0);
        chk("R10", "sp_addr", sp_addr, 15'h123);
        // R8: reserved bits flipped leave every output unchanged
        for (int t = 0; t < 40; t++) begin
            logic [7:0] lb;
            logic [1:0] gb;
            logic [2:0] sb;
            logic [31:0] mb;
            logic [5:0] ref_out;
            logic [14:0] ref_addr;
            lb = 8'($urandom); gb = 2'($urandom); sb = 3'($urandom); mb = $urandom;
            apply("R8", 1, gb, lb & 8'h87, sb, mb);
            ref_out  = {reg_we, reg_file, reg_idx, sp_we};
            ref_addr = sp_addr;
            apply("R8", 1, gb, lb | 8'h78, sb, mb);
            chk("R8", "flags", {reg_we, reg_file, reg_idx, sp_we}, ref_out);
            chk("R8", "addr",  sp_addr, ref_addr);
        end
        // Random mix across all groups and codes
        for (int t = 0; t < 400; t++) begin
            if (t % 50 == 0)
                for (int k = 0; k < 8; k++) rf[k] = {$urandom, $urandom};
            apply("R2 R3 R4 R5 R6 R7 R9", 1'($urandom % 5 != 0), 2'($urandom),
                  8'($urandom), 3'($urandom), $urandom);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule